// File: doc/BRIEF.md
# Four-Write Two-Read Register File

This block is a register file of 144 entries with four write ports and two read ports. All ports share one single-rate clock. There is no faster internal clock that time-shares a single array. Each write port owns a private storage bank and is the only port that writes it. A write updates only its own bank.

A small pointer table holds one entry per address, recording which write port stored that address most recently. Each read port first looks up the pointer for its address. It then takes the word from the bank that the pointer names.

Reads are registered, and a read of an address that is being written in the same cycle returns the previous contents. When several ports write one address in the same cycle, the port with the highest index owns the result. Entry count, word width and port counts are parameters. The defaults are 144 entries, 78 bits, four write ports and two read ports.

Top module: `regfile_4w2r`

## Requirements
- R1: While reset is asserted, and afterwards until the first write, every read output is zero. Reset points all pointer entries at write port 0 and clears every bank.
- R2: After a write of data D to address A, a later read of A returns D, provided no other write to A comes in between.
- R3: Each read returns the value from the most recent write to that address, whichever port made it. For example, if port 1 writes A and port 0 writes A later, the read returns port 0's data.
- R4: If more than one write port writes the same address in one cycle, the port with the highest index wins. Later reads of that address return its data.
- R5: Reads take one clock. The read enable and address are sampled on a rising edge, and `rd_data` shows the result right after that edge.
- R6: A read sampled on the same edge as a write to the same address returns the contents from before that write.
- R7: A read port whose enable is low at the sampling edge drives zero on its `rd_data` slice after that edge.
- R8: An address of 144 or more is out of range. Writes to it are dropped and do not alias onto any entry, and reads of it return zero.
- R9: The two read ports work independently and may read the same address in the same cycle. Read port r uses slice `[r*78 +: 78]` of `rd_data`, `rd_addr[r*8 +: 8]` and `rd_en[r]`. Write port p uses `wr_data[p*78 +: 78]`, `wr_addr[p*8 +: 8]` and `wr_en[p]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all ports |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 4 | Write enable, one bit per write port |
| wr_addr | input | 32 | Write addresses, 8 bits per port |
| wr_data | input | 312 | Write data, 78 bits per port |
| rd_en | input | 2 | Read enable, one bit per read port |
| rd_addr | input | 16 | Read addresses, 8 bits per port |
| rd_data | output | 156 | Registered read data, 78 bits per port |

## Verification
The bench targets collisions in which two, three or four ports write one address in the same cycle. A design with the wrong priority would return a lower port's word there. It also reads an address while that address is being written. A design that forwards the new data, or that updates the pointer before steering the read, would return the new word instead of the old one. It further rewrites an address from a lower port after a higher port has written it, which catches a pointer table that keeps a stale owner. Finally, it writes out-of-range addresses, which catches truncated address decoding that aliases onto entry 6.

// File: rtl/regfile_4w2r.sv
module regfile_4w2r #(
  parameter int DEPTH = 144,
  parameter int WIDTH = 78,
  parameter int NWR   = 4,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = $clog2(NWR)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NWR-1:0]       wr_en,
  input  logic [NWR*AW-1:0]    wr_addr,
  input  logic [NWR*WIDTH-1:0] wr_data,
  input  logic [NRD-1:0]       rd_en,
  input  logic [NRD*AW-1:0]    rd_addr,
  output logic [NRD*WIDTH-1:0] rd_data
);
  localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

  logic [PW-1:0] lvt [DEPTH];
  logic [NWR*NRD*WIDTH-1:0] bank_rd;

  for (genvar k = 0; k < NWR; k++) begin : g_bank
    logic [WIDTH-1:0] mem [DEPTH];
    wire [AW-1:0] wa = wr_addr[k*AW +: AW];
    wire          wok = {1'b0, wa} < LIMIT;

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en[k] && wok) begin
        mem[wa] <= wr_data[k*WIDTH +: WIDTH];
      end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_port
      wire [AW-1:0] ra = rd_addr[r*AW +: AW];
      assign bank_rd[(k*NRD+r)*WIDTH +: WIDTH] =
        ({1'b0, ra} < LIMIT) ? mem[ra] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) lvt[i] <= '0;
    end else begin
      for (int p = 0; p < NWR; p++)
        if (wr_en[p] && ({1'b0, wr_addr[p*AW +: AW]} < LIMIT))
          lvt[wr_addr[p*AW +: AW]] <= PW'(p);
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_read
    wire [AW-1:0] ra = rd_addr[r*AW +: AW];
    wire          rok = {1'b0, ra} < LIMIT;
    logic [PW-1:0]    sel;
    logic [WIDTH-1:0] pick, q;

    always_comb begin
      sel  = rok ? lvt[ra] : '0;
      pick = '0;
      for (int k = 0; k < NWR; k++)
        if (sel == PW'(k)) pick = bank_rd[(k*NRD+r)*WIDTH +: WIDTH];
    end

    always_ff @(posedge clk) begin
      if (rst)                 q <= '0;
      else if (rd_en[r] && rok) q <= pick;
      else                     q <= '0;
    end

    assign rd_data[r*WIDTH +: WIDTH] = q;
  end
endmodule

// File: rtl/regfile_4w2r_chk.sv
module regfile_4w2r_chk #(
  parameter int DEPTH = 144,
  parameter int WIDTH = 78,
  parameter int NWR   = 4,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NWR-1:0]       wr_en,
  input logic [NWR*AW-1:0]    wr_addr,
  input logic [NWR*WIDTH-1:0] wr_data,
  input logic [NRD-1:0]       rd_en,
  input logic [NRD*AW-1:0]    rd_addr,
  input logic [NRD*WIDTH-1:0] rd_data
);
  localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);
  wire [AW-1:0] wa1 = wr_addr[1*AW +: AW];
  wire [AW-1:0] wa3 = wr_addr[3*AW +: AW];
  wire [AW-1:0] ra0 = rd_addr[0 +: AW];
  wire [AW-1:0] ra1 = rd_addr[AW +: AW];
  wire [WIDTH-1:0] rd0 = rd_data[0 +: WIDTH];
  wire [WIDTH-1:0] rd1 = rd_data[WIDTH +: WIDTH];

  p_disabled_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_en[0] |=> rd0 == '0);

  p_out_of_range_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en[1] && ({1'b0, ra1} >= LIMIT)) |=> rd1 == '0);

  p_top_port_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en[3] && ({1'b0, wa3} < LIMIT)) ##1 (rd_en[0] && ra0 == $past(wa3))
    |=> rd0 == $past(wr_data[3*WIDTH +: WIDTH], 2));

  p_single_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en == 4'b0010 && ({1'b0, wa1} < LIMIT)) ##1 (rd_en[1] && ra1 == $past(wa1))
    |=> rd1 == $past(wr_data[1*WIDTH +: WIDTH], 2));
endmodule

bind regfile_4w2r regfile_4w2r_chk #(
  .DEPTH(DEPTH), .WIDTH(WIDTH), .NWR(NWR), .NRD(NRD)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/sim_regfile_4w2r.sv
`timescale 1ns/1ps
module sim_regfile_4w2r;
  localparam int DEPTH = 144, W = 78, NW = 4, NR = 2, AW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [NW-1:0] we;
  logic [AW-1:0] wa [NW];
  logic [W-1:0]  wd [NW];
  logic [NR-1:0] re;
  logic [AW-1:0] ra [NR];
  logic [NW*AW-1:0] wa_f;
  logic [NW*W-1:0]  wd_f;
  logic [NR*AW-1:0] ra_f;
  logic [NR*W-1:0]  rd_data;

  always_comb begin
    for (int p = 0; p < NW; p++) begin
      wa_f[p*AW +: AW] = wa[p];
      wd_f[p*W +: W]   = wd[p];
    end
    for (int r = 0; r < NR; r++) ra_f[r*AW +: AW] = ra[r];
  end

  regfile_4w2r u0 (
    .clk(clk), .rst(rst), .wr_en(we), .wr_addr(wa_f), .wr_data(wd_f),
    .rd_en(re), .rd_addr(ra_f), .rd_data(rd_data)
  );

  logic [W-1:0] model [DEPTH];
  logic [W-1:0] expv [NR];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [W-1:0] rnd_word();
    return W'({$urandom, $urandom, $urandom});
  endfunction

  function automatic logic [W-1:0] expect_read(input bit en, input logic [AW-1:0] a);
    return (en && a < DEPTH) ? model[a] : '0;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    we = '0; re = '0;
    for (int p = 0; p < NW; p++) begin wa[p] = '0; wd[p] = '0; end
    for (int r = 0; r < NR; r++) ra[r] = '0;
  endtask

  task automatic step(input string tag);
    for (int r = 0; r < NR; r++) expv[r] = expect_read(re[r], ra[r]);
    for (int p = 0; p < NW; p++)
      if (we[p] && wa[p] < DEPTH) model[wa[p]] = wd[p];
    @(posedge clk); #1;
    for (int r = 0; r < NR; r++) check(tag, rd_data[r*W +: W], expv[r]);
    idle();
  endtask

  task automatic wr(input int p, input int a, input logic [W-1:0] d);
    we[p] = 1'b1; wa[p] = AW'(a); wd[p] = d;
  endtask

  task automatic rd(input int r, input int a);
    re[r] = 1'b1; ra[r] = AW'(a);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", rd_data[0 +: W], '0);
    check("R1 reset", rd_data[W +: W], '0);
    @(negedge clk) rst = 1'b0;

    rd(0, 0); rd(1, 143); step("R1");

    wr(2, 5, 78'h2AB_CDEF_0123_4567_89AB); wr(0, 6, 78'h11_2233_4455_6677_8899); step("R2");
    rd(0, 5); rd(1, 5); step("R9");
    rd(0, 6); step("R5");

    wr(1, 7, 78'h1_1111_1111); step("R3");
    wr(0, 7, 78'h2_2222_2222); step("R3");
    rd(1, 7); step("R3");

    for (int p = 0; p < NW; p++) wr(p, 9, W'(p + 78'h100));
    step("R4");
    for (int p = 0; p < 3; p++) wr(p, 10, W'(p + 78'h200));
    step("R4");
    rd(0, 9); rd(1, 10); step("R4");
    wr(0, 9, 78'h3FF_EEEE); wr(1, 9, 78'h77); step("R4");
    rd(0, 9); step("R4");

    rd(0, 9); rd(1, 5); wr(0, 9, 78'hDEAD); wr(3, 5, 78'hBEEF); step("R6");
    rd(0, 9); rd(1, 5); step("R6");

    ra[0] = 8'd5; ra[1] = 8'd9; step("R7");

    wr(0, 150, 78'hBAD); wr(3, 200, 78'hBAD2); rd(0, 150); rd(1, 255); step("R8");
    rd(0, 6); rd(1, 56); step("R8");

    for (int n = 0; n < 3000; n++) begin
      for (int p = 0; p < NW; p++) begin
        we[p] = ($urandom % 3) != 0;
        wa[p] = ($urandom % 4 == 0) ? AW'($urandom % 160) : AW'($urandom % 12);
        wd[p] = rnd_word();
      end
      for (int r = 0; r < NR; r++) begin
        re[r] = ($urandom % 5) != 0;
        ra[r] = ($urandom % 4 == 0) ? AW'($urandom % 160) : AW'($urandom % 12);
      end
      step("R2 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule